// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. It watches an asynchronous input pin and, on an edge of the kind selected by a 2-bit edge-select field, copies the free-running counter value it is given into a capture register. Each capture sets an event flag. The flag drives an interrupt request when the interrupt enable is high, and software clears it with a write-one strobe.

The pin first passes through a reset-cleared synchronizer of `SYNC_STAGES` flops (two by default). A small edge-watch state machine then compares each synchronized sample with the one before it. This machine has three states. `EDGE_FILL` holds detection off after reset until the synchronizer and the history flop contain real pin samples, so the pin level present at reset release does not count as an edge. `EDGE_IDLE` is the state while the channel is not in capture mode or the edge select is "none". `EDGE_WATCH` reports qualifying edges. Its transitions are as follows. FILL goes to WATCH or to IDLE once priming is complete, depending on whether the channel is enabled. IDLE goes to WATCH when capture mode is on and the edge select is not "none". WATCH goes back to IDLE when either of those conditions is lost.

A second machine holds the flag. It has two states, `FLAG_CLEAR` and `FLAG_SET`. CLEAR goes to SET on a capture. SET goes to CLEAR on a permitted write-one strobe. SET stays in SET if a capture coincides with the strobe. A strobe is permitted only while the timer enable or the accumulator enable is high. The counter itself, pulse accumulation and register decoding are outside this block.

Top module: `ic_capture_channel`

## Requirements
- R1: While `rst_n` is low, `cap_value` is 0, `cap_flag` is 0 and `irq` is 0.
- R2: `edge_sel` encodes 2'b00 = no capture, 2'b01 = rising edges only, 2'b10 = falling edges only, 2'b11 = both edges; an edge of a kind not selected leaves `cap_value` and `cap_flag` unchanged.
- R3: When `ic_pin` changes before clock edge n and the edge is selected, `cap_value` takes the `cnt_val` present at clock edge n+2 and `cap_flag` rises at that same edge, not earlier.
- R4: While `ic_mode` is 0, pin edges cause no capture and do not set the flag; after `ic_mode` returns to 1 with a steady pin no capture occurs, and later edges are captured again.
- R5: `irq` is high exactly when `cap_flag` is high and `irq_en` is high.
- R6: A `flag_clr` pulse clears `cap_flag` at the next clock edge when `timer_en` or `accum_en` is high; with both low the pulse is ignored and the flag stays set.
- R7: If a capture and a permitted `flag_clr` fall on the same clock edge, the capture wins: `cap_value` is updated and `cap_flag` stays 1.
- R8: An edge captured while `cap_flag` is already 1 overwrites `cap_value` and leaves `cap_flag` at 1.
- R9: A pin level already present when reset is released is not treated as an edge.
- R10: With both edges selected, a pulse held for three clocks yields two captures whose values are three counts apart, the second overwriting the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_pin | input | 1 | Asynchronous capture pin |
| ic_mode | input | 1 | 1 = channel in input-capture mode |
| edge_sel | input | 2 | Edge select (see R2) |
| cnt_val | input | CNT_W (16) | Current timer counter value |
| irq_en | input | 1 | Interrupt enable for the flag |
| flag_clr | input | 1 | Write-one strobe to clear the flag |
| timer_en | input | 1 | Timer enable, permits flag clearing |
| accum_en | input | 1 | Accumulator enable, permits flag clearing |
| cap_value | output | CNT_W (16) | Captured counter value |
| cap_flag | output | 1 | Capture event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all four edge-select codes against both pin directions and computes the expected capture from the counter it drives itself. This catches a swapped rise/fall decode, which would capture on the wrong edge. It checks the flag one cycle before the capture is due, so a design with an extra or missing synchronizer stage is caught by a value off by one count or by a flag that rises early. It holds the pin high through reset to expose a design that does not prime its history flop and would report a false rising edge. It also lines up a clear strobe with a capture edge and strobes with both enables low, catching a design that lets the clear win or ignores the enable gate.

// File: rtl/ic_capture_pkg.sv
package ic_capture_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        EDGE_FILL  = 2'b00,
        EDGE_IDLE  = 2'b01,
        EDGE_WATCH = 2'b10
    } edge_state_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

endpackage

// File: rtl/ic_sync.sv
module ic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/ic_edge_fsm.sv
module ic_edge_fsm
    import ic_capture_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_lvl,
    input  logic       capture_en,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);

    localparam int FILL_W = $clog2(SYNC_STAGES + 2);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SYNC_STAGES);

    edge_state_e       state, state_nx;
    logic [FILL_W-1:0] fill_cnt;
    logic              fill_done;
    logic              prev_lvl;
    logic              active;
    logic              rise, fall;
    edge_sel_e         sel;

    assign sel       = edge_sel_e'(edge_sel);
    assign active    = capture_en && (sel != EDGE_NONE);
    assign fill_done = (fill_cnt == FILL_LAST);
    assign rise      = sync_lvl && !prev_lvl;
    assign fall      = !sync_lvl && prev_lvl;

    // history flop: always follows the synchronized level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= sync_lvl;
    end

    // priming counter, saturates once pipeline holds real samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          fill_cnt <= '0;
        else if (!fill_done) fill_cnt <= fill_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EDGE_FILL;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            EDGE_FILL:  if (fill_done) state_nx = active ? EDGE_WATCH : EDGE_IDLE;
            EDGE_IDLE:  if (active)    state_nx = EDGE_WATCH;
            EDGE_WATCH: if (!active)   state_nx = EDGE_IDLE;
            default:                   state_nx = EDGE_FILL;
        endcase
    end

    // outputs
    always_comb begin
        edge_hit = 1'b0;
        unique case (state)
            EDGE_FILL:  edge_hit = 1'b0;
            EDGE_IDLE:  edge_hit = 1'b0;
            EDGE_WATCH: edge_hit = active &&
                                   ((rise && sel[0]) || (fall && sel[1]));
            default:    edge_hit = 1'b0;
        endcase
    end

    // no edge may be reported before the synchronizer is primed
    assert_primed_before_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> fill_done);

    // a reported edge must be a real change of the synchronized level
    assert_hit_is_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (prev_lvl != $past(prev_lvl)));

endmodule

// File: rtl/ic_flag_fsm.sv
module ic_flag_fsm
    import ic_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_strobe,
    input  logic clr_allowed,
    output logic flag
);

    flag_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_CLEAR;
        else        state <= state_nx;
    end

    // next state: capture has priority over clear
    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_CLEAR: if (set_evt) state_nx = FLAG_SET;
            FLAG_SET:   if (!set_evt && clr_strobe && clr_allowed)
                            state_nx = FLAG_CLEAR;
            default:    state_nx = FLAG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            FLAG_CLEAR: flag = 1'b0;
            FLAG_SET:   flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

    assert_capture_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    assert_clear_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_strobe && !clr_allowed) |=> flag);

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_strobe && clr_allowed && !set_evt) |=> !flag);

endmodule

// File: rtl/ic_capture_channel.sv
module ic_capture_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ic_pin,
    input  logic             ic_mode,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             timer_en,
    input  logic             accum_en,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             irq
);

    logic pin_sync;
    logic cap_evt;

    ic_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ic_pin),
        .q_sync  (pin_sync)
    );

    ic_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lvl   (pin_sync),
        .capture_en (ic_mode),
        .edge_sel   (edge_sel),
        .edge_hit   (cap_evt)
    );

    ic_flag_fsm u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_evt     (cap_evt),
        .clr_strobe  (flag_clr),
        .clr_allowed (timer_en || accum_en),
        .flag        (cap_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_value <= '0;
        else if (cap_evt) cap_value <= cnt_val;
    end

    assign irq = cap_flag && irq_en;

    assert_capture_loads_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_flag && (cap_value == $past(cnt_val))));

    assert_no_capture_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ic_mode |=> $stable(cap_value));

    assert_flag_rise_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> $past(ic_mode));

endmodule

// File: tb/test_ic_capture_channel.sv
module test_ic_capture_channel;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        ic_pin;
    logic        ic_mode;
    logic [1:0]  edge_sel;
    logic [15:0] cnt_val;
    logic        irq_en;
    logic        flag_clr;
    logic        timer_en;
    logic        accum_en;
    logic [15:0] cap_value;
    logic        cap_flag;
    logic        irq;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [15:0] exp_cap  = 16'h0;

    ic_capture_channel i_ic_capture_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ic_pin    (ic_pin),
        .ic_mode   (ic_mode),
        .edge_sel  (edge_sel),
        .cnt_val   (cnt_val),
        .irq_en    (irq_en),
        .flag_clr  (flag_clr),
        .timer_en  (timer_en),
        .accum_en  (accum_en),
        .cap_value (cap_value),
        .cap_flag  (cap_flag),
        .irq       (irq)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic step();
        @(negedge clk);
        cnt_val = cnt_val + 16'd1;
    endtask

    task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive a pin change, check the flag one cycle early, then value and flag
    task automatic edge_case(logic np, logic expect_cap, logic pre_flag, string tag);
        logic [15:0] v;
        step();
        ic_pin = np;
        v = cnt_val;
        step();
        step();
        chk1({tag, " R3 flag not early"}, cap_flag, pre_flag);
        step();
        if (expect_cap) exp_cap = v + 16'd2;
        chk16({tag, " value"}, cap_value, exp_cap);
        chk1({tag, " flag"}, cap_flag, pre_flag | expect_cap);
    endtask

    task automatic clear_flag();
        step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        step();
        chk1("R6 clear with enable", cap_flag, 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] v2;
        rst_n    = 1'b0;
        ic_pin   = 1'b1;
        ic_mode  = 1'b1;
        edge_sel = 2'b11;
        cnt_val  = 16'h1000;
        irq_en   = 1'b1;
        flag_clr = 1'b0;
        timer_en = 1'b1;
        accum_en = 1'b0;

        repeat (3) step();
        chk16("R1 reset value", cap_value, 16'h0);
        chk1("R1 reset flag", cap_flag, 1'b0);
        chk1("R1 reset irq", irq, 1'b0);

        step();
        rst_n = 1'b1;
        repeat (8) step();
        chk1("R9 high pin at reset not an edge", cap_flag, 1'b0);
        chk16("R9 value untouched", cap_value, 16'h0);

        // R2 sweep over every edge-select code and both directions
        for (int s = 0; s < 4; s++) begin
            logic [1:0] sv;
            sv = 2'(s);
            edge_sel = sv;
            repeat (4) step();
            edge_case(1'b0, sv[1], 1'b0, "R2 falling");
            if (sv[1]) clear_flag();
            edge_case(1'b1, sv[0], 1'b0, "R2 rising");
            if (sv[0]) clear_flag();
        end

        // R5 interrupt gating
        edge_sel = 2'b11;
        repeat (2) step();
        edge_case(1'b0, 1'b1, 1'b0, "R5 setup");
        chk1("R5 irq with enable", irq, 1'b1);
        step();
        irq_en = 1'b0;
        #1;
        chk1("R5 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk1("R5 irq restored", irq, 1'b1);

        // R8 overwrite while flag set
        edge_case(1'b1, 1'b1, 1'b1, "R8 overwrite");

        // R6 clear ignored without enables, then works with accumulator enable
        timer_en = 1'b0;
        accum_en = 1'b0;
        step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        step();
        chk1("R6 clear ignored", cap_flag, 1'b1);
        chk16("R6 value kept", cap_value, exp_cap);
        accum_en = 1'b1;
        step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        step();
        chk1("R6 clear via accumulator enable", cap_flag, 1'b0);
        accum_en = 1'b0;
        timer_en = 1'b1;

        // R7 capture and clear on the same edge
        step();
        ic_pin = 1'b0;
        v = cnt_val;
        step();
        step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        exp_cap = v + 16'd2;
        chk1("R7 capture beats clear flag", cap_flag, 1'b1);
        chk16("R7 capture beats clear value", cap_value, exp_cap);
        clear_flag();

        // R4 capture mode off
        ic_mode = 1'b0;
        step();
        ic_pin = 1'b1;
        repeat (6) step();
        chk1("R4 mode off flag", cap_flag, 1'b0);
        chk16("R4 mode off value", cap_value, exp_cap);
        ic_mode = 1'b1;
        repeat (4) step();
        chk1("R4 re-enable no stale edge", cap_flag, 1'b0);
        edge_case(1'b0, 1'b1, 1'b0, "R4 capture after re-enable");
        clear_flag();

        // R10 three-cycle pulse, both edges
        step();
        ic_pin = 1'b1;
        v = cnt_val;
        repeat (3) step();
        chk16("R10 first edge value", cap_value, v + 16'd2);
        chk1("R10 first edge flag", cap_flag, 1'b1);
        ic_pin = 1'b0;
        v2 = cnt_val;
        repeat (3) step();
        chk16("R10 second edge value", cap_value, v2 + 16'd2);
        chk16("R10 captures three apart", cap_value - (v + 16'd2), 16'd3);

        summary();
        $finish;
    end

endmodule